// File: doc/BRIEF.md
# Programmable-Tap Seeded Data Scrambler

This block whitens a serial transmit bit stream with a seven-stage shift register. Software chooses both the feedback polynomial and the starting state through an 8-bit write port. One configuration register enables individual delay taps. A second register holds the preset value that a start pulse copies into the shift register.

After a start pulse, each clock with the enable input high takes one input data bit. The block XORs that bit with the parity of the enabled stages and returns the result as one registered scrambled bit. The same scrambled bit is shifted into the first stage, so the register runs in self-synchronising scrambler form. With no taps enabled, the data passes through unchanged.

Top module: `prog_scrambler`

## Requirements
- R1: While reset is asserted and after it is released, `data_o` and `valid_o` are 0, and both configuration registers hold 0.
- R2: A write with `cfg_we_i` high to address 0 sets the seed register, and a write to address 1 sets the tap register. The new value is used from the next cycle. Bit 7 of the written byte is ignored, and writes to addresses 2 and 3 change nothing.
- R3: A start pulse copies the 7-bit seed into the shift register. In the cycle after the start pulse, `valid_o` is 0 and `data_o` keeps its previous value.
- R4: When `en_i` is high and `start_i` is low, the next cycle shows `valid_o` = 1 and `data_o` = `data_i` XOR the parity of (state AND taps). State bit k is delay z^-(k+1), and tap bit k enables that delay.
- R5: On each enabled clock the state shifts left: stage k+1 takes stage k, and the scrambled output bit enters stage 1 (bit 0).
- R6: When `start_i` and `en_i` are high in the same cycle, the seed load wins. No bit is scrambled and `valid_o` is 0 in the next cycle.
- R7: With a tap value of 0, `data_o` equals the `data_i` presented one cycle earlier.
- R8: With both `en_i` and `start_i` low, the state is held, `valid_o` is 0 in the next cycle, and `data_o` holds its value.
- R9: Tap value 0x48 (bits 6 and 3, polynomial 1 + x^-4 + x^-7) with a nonzero seed and all-zero data produces the maximal-length sequence. The output repeats after 127 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration address (0 seed, 1 taps) |
| cfg_wdata_i | input | 8 | Configuration write data |
| start_i | input | 1 | Load seed into shift register |
| en_i | input | 1 | Scramble one bit this clock |
| data_i | input | 1 | Input data bit |
| data_o | output | 1 | Scrambled bit, registered |
| valid_o | output | 1 | data_o carries a bit scrambled in the previous cycle |

## Verification
Every result is due on the rising edge after its stimulus:
- A scrambled bit and its `valid_o` appear one edge after the enabled clock.
- A seed load shows up as the first bit scrambled after the start pulse.
- A configuration write takes effect at the edge that stores it, so it first shapes the bit scrambled on the following clock.

The bench drives inputs on the falling edge and checks on the next falling edge. This places each check exactly one rising edge after its stimulus. A bit-level model is advanced in step with the checks and runs over several tap and seed pairs, including the 127-bit period of the maximal polynomial.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned CFG_DW  = 8;
  localparam int unsigned LFSR_N  = 7;
  localparam int unsigned CFG_AW  = 2;
  localparam logic [CFG_AW-1:0] ADDR_SEED = 2'd0;
  localparam logic [CFG_AW-1:0] ADDR_TAPS = 2'd1;
endpackage

// File: rtl/scr_cfg_regs.sv
module scr_cfg_regs #(
  parameter int unsigned N  = 7,
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 2,
  parameter logic [AW-1:0] SEED_A = '0,
  parameter logic [AW-1:0] TAPS_A = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [N-1:0]  seed_o,
  output logic [N-1:0]  taps_o
);
  logic [N-1:0] seed_q, taps_q;

  // upper data bits are reserved and dropped
  generate
    if (DW > N) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wdata_i[DW-1:N];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q <= '0;
      taps_q <= '0;
    end else if (we_i) begin
      if (addr_i == SEED_A) seed_q <= wdata_i[N-1:0];
      if (addr_i == TAPS_A) taps_q <= wdata_i[N-1:0];
    end
  end

  assign seed_o = seed_q;
  assign taps_o = taps_q;

  a_r2_other_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i != SEED_A && addr_i != TAPS_A) |=> ($stable(seed_q) && $stable(taps_q)));
  a_r2_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(seed_q) && $stable(taps_q)));
endmodule

// File: rtl/scr_lfsr_core.sv
module scr_lfsr_core #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] seed_i,
  input  logic [N-1:0] taps_i,
  input  logic         start_i,
  input  logic         en_i,
  input  logic         data_i,
  output logic         data_o,
  output logic         valid_o
);
  logic [N-1:0] state_q;
  logic [N-1:0] term;
  logic         fb, scr_bit, dout_q, vld_q;

  // state bit k is delay z^-(k+1)
  for (genvar k = 0; k < N; k++) begin : g_tap
    assign term[k] = state_q[k] & taps_i[k];
  end

  assign fb      = ^term;
  assign scr_bit = data_i ^ fb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      dout_q  <= 1'b0;
      vld_q   <= 1'b0;
    end else if (start_i) begin
      state_q <= seed_i;
      vld_q   <= 1'b0;
    end else if (en_i) begin
      state_q <= {state_q[N-2:0], scr_bit};
      dout_q  <= scr_bit;
      vld_q   <= 1'b1;
    end else begin
      vld_q   <= 1'b0;
    end
  end

  assign data_o  = dout_q;
  assign valid_o = vld_q;

  a_r3_start_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == $past(seed_i) && !valid_o && $stable(data_o)));
  a_r4_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !start_i) |=> valid_o);
  a_r5_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !start_i) |=> (state_q[N-1:1] == $past(state_q[N-2:0]) && state_q[0] == data_o));
  a_r6_start_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && en_i) |=> !valid_o);
  a_r7_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !start_i && taps_i == '0) |=> data_o == $past(data_i));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !start_i) |=> ($stable(state_q) && $stable(data_o) && !valid_o));
endmodule

// File: rtl/prog_scrambler.sv
module prog_scrambler #(
  parameter int unsigned N  = scr_pkg::LFSR_N,
  parameter int unsigned DW = scr_pkg::CFG_DW,
  parameter int unsigned AW = scr_pkg::CFG_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [DW-1:0] cfg_wdata_i,
  input  logic          start_i,
  input  logic          en_i,
  input  logic          data_i,
  output logic          data_o,
  output logic          valid_o
);
  logic [N-1:0] seed, taps;

  scr_cfg_regs #(
    .N(N), .DW(DW), .AW(AW),
    .SEED_A(scr_pkg::ADDR_SEED), .TAPS_A(scr_pkg::ADDR_TAPS)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .seed_o  (seed),
    .taps_o  (taps)
  );

  scr_lfsr_core #(.N(N)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .seed_i  (seed),
    .taps_i  (taps),
    .start_i (start_i),
    .en_i    (en_i),
    .data_i  (data_i),
    .data_o  (data_o),
    .valid_o (valid_o)
  );

  a_r1_reset_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!valid_o && !data_o));
endmodule

// File: tb/prog_scrambler_tb.sv
module prog_scrambler_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, start = 1'b0, en = 1'b0, din = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic dout, vld;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  logic [6:0] m_state = '0, m_seed = '0, m_taps = '0;
  logic exp_d = 1'b0, exp_v = 1'b0;

  // taps, seed, length, data bits (MSB first)
  localparam logic [39:0] VEC [0:4] = '{
    {8'h48, 8'h7F, 8'd16, 16'h0000},
    {8'h48, 8'h01, 8'd16, 16'hA5C3},
    {8'h00, 8'h55, 8'd16, 16'h1234},
    {8'h7F, 8'h2A, 8'd12, 16'h0F0F},
    {8'h09, 8'h40, 8'd16, 16'hFFFF}
  };

  always #5 clk = ~clk;

  prog_scrambler u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .start_i(start), .en_i(en), .data_i(din),
    .data_o(dout), .valid_o(vld)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // call at falling edge; returns at next falling edge
  task automatic cfg(logic [1:0] a, logic [7:0] v);
    we = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    we = 1'b0;
    if (a == 2'd0) m_seed = v[6:0];
    if (a == 2'd1) m_taps = v[6:0];
  endtask

  task automatic step(logic st, logic e, logic d, string req);
    logic o;
    start = st; en = e; din = d;
    if (st) begin
      m_state = m_seed; exp_v = 1'b0;
    end else if (e) begin
      o = d ^ (^(m_state & m_taps));
      m_state = {m_state[5:0], o};
      exp_d = o; exp_v = 1'b1;
    end else begin
      exp_v = 1'b0;
    end
    @(negedge clk);
    start = 1'b0; en = 1'b0; din = 1'b0;
    chk(req, {6'd0, vld, dout}, {6'd0, exp_v, exp_d});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R1 in reset", {6'd0, vld, dout}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {6'd0, vld, dout}, 8'h00);
    // R1: registers zero -> start loads 0 and taps 0 passes data
    step(1'b1, 1'b0, 1'b0, "R1 start");
    step(1'b0, 1'b1, 1'b1, "R1 zero cfg");
    step(1'b0, 1'b1, 1'b0, "R1 zero cfg");

    for (int v = 0; v < 5; v++) begin
      cfg(2'd1, VEC[v][39:32]);
      cfg(2'd0, VEC[v][31:24]);
      step(1'b1, 1'b0, 1'b0, "R3 start");
      for (int b = 0; b < int'(VEC[v][23:16]); b++)
        step(1'b0, 1'b1, VEC[v][15-b], (VEC[v][39:32] == 8'h00) ? "R7 passthrough" : "R4 R5 vector");
    end

    // R2: bit 7 ignored, taps 0xC8 acts as 0x48
    cfg(2'd1, 8'hC8);
    cfg(2'd0, 8'h93);
    step(1'b1, 1'b0, 1'b0, "R2 start");
    for (int b = 0; b < 10; b++) step(1'b0, 1'b1, b[0], "R2 bit7 ignored");
    // R2: unused addresses change nothing
    cfg(2'd2, 8'hFF);
    cfg(2'd3, 8'h00);
    for (int b = 0; b < 10; b++) step(1'b0, 1'b1, b[1], "R2 unused addr");
    step(1'b1, 1'b0, 1'b0, "R2 restart");
    for (int b = 0; b < 8; b++) step(1'b0, 1'b1, 1'b0, "R2 seed kept");

    // R8: idle holds state and output
    step(1'b0, 1'b0, 1'b1, "R8 idle");
    step(1'b0, 1'b0, 1'b0, "R8 idle");
    for (int b = 0; b < 8; b++) step(1'b0, 1'b1, 1'b0, "R8 resume");

    // R6: start and enable together
    cfg(2'd0, 8'h35);
    step(1'b1, 1'b1, 1'b1, "R6 start wins");
    for (int b = 0; b < 8; b++) step(1'b0, 1'b1, 1'b0, "R6 after start");

    // R9: maximal length, period 127
    begin
      logic [126:0] seq;
      cfg(2'd1, 8'h48);
      cfg(2'd0, 8'h01);
      step(1'b1, 1'b0, 1'b0, "R9 start");
      for (int b = 0; b < 127; b++) begin
        step(1'b0, 1'b1, 1'b0, "R9 sequence");
        seq[b] = dout;
      end
      chk("R9 ones count", 8'($countones(seq)), 8'd64);
      for (int b = 0; b < 20; b++) begin
        step(1'b0, 1'b1, 1'b0, "R9 sequence");
        chk("R9 period", {7'd0, dout}, {7'd0, seq[b]});
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule